// File: doc/BRIEF.md
# Event-Selectable Performance Counter Bank

This block holds six 32-bit event counters that a core uses to profile its own execution. Each clock it receives a count of the instructions retired in that cycle, between zero and a small maximum. Each counter either adds that count or advances by one per clock, as its event selection decides. Counters 1 to 4 take an 8-bit event code from a selection register. Counter 5 always counts instructions and counter 6 always counts cycles. A mode register holds three freeze controls and two overflow enables.

When a counter's overflow enable is set and an increment carries it to or past the sign bit (0x80000000), the counter stops at exactly 0x80000000 and raises its overflow output for one cycle. The alert logic downstream turns these pulses into interrupts. Software reaches every counter and both control registers through a flat select/write/read port.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset, all six counters, the mode register and the selection register read zero. `regSel` values 0 to 5 select counters 1 to 6, value 6 selects the mode register and value 7 the selection register. `rdData` shows the selected register in the same cycle.
- R2: Mode bit 0 (freeze-all) set stops all six counters, whatever the other settings are.
- R3: Mode bit 1 set stops counters 1 to 4. Counters 1 to 4 also stay idle while the selection register is entirely zero.
- R4: Mode bit 2 set stops counters 5 and 6. Otherwise counter 5 adds the instruction count and counter 6 adds one every clock.
- R5: Counter 1 takes its code from selection bits [31:24]. It counts instructions for 0x02 or 0xFE and cycles for 0x1E or 0xF0.
- R6: Counter 2 takes its code from bits [23:16] and counter 3 from bits [15:8]. Code 0x02 counts instructions and code 0x1E counts cycles. Any other code leaves the counter idle.
- R7: Counter 4 takes its code from bits [7:0]. Codes 0x02 and 0xFA count instructions and code 0x1E counts cycles. Under 0xFA it advances only while `runLatch` is high.
- R8: If an enabled overflow condition meets an increment whose result is at or above 0x80000000, the counter becomes exactly 0x80000000 and its `ovfPulse` bit is high for the cycle that follows that edge. With the enable clear, the counter keeps adding past the sign bit and no pulse occurs.
- R9: Mode bit 3 is the overflow enable of counter 1. Mode bit 4 is the shared overflow enable of counters 2 to 6.
- R10: An instruction-counting counter adds `insnCount` in one cycle, so it may add more than one. A cycle-counting counter adds exactly one per clock. A write to either control register takes effect from the next clock.
- R11: A write to a counter stores the 32-bit `wrData`. If the counter also increments in that cycle, the write wins and no overflow pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 3 | Register select for read and write |
| wrEn | input | 1 | Write strobe for the selected register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Contents of the selected register |
| insnCount | input | INSN_W (3) | Instructions retired this cycle |
| runLatch | input | 1 | Run indication that gates code 0xFA on counter 4 |
| ovfPulse | output | 6 | One-cycle overflow flag per counter |

## Verification
The assertions assume that `regSel` and `wrData` are valid whenever `wrEn` is high. They also assume that `insnCount` needs no handshake and is sampled at every edge. The stimulus writes registers only while freeze-all is set, or on purpose in the single write-versus-increment cycle. All readback takes place under freeze-all, so the counter values stay still while the scoreboard compares them. Instruction counts change only between whole run windows, which gives each window an exact number of counting edges for the expected values.

// File: rtl/evtc_pkg.sv
package evtc_pkg;
  localparam int NUM_CNT = 6;
  localparam int NUM_SEL = 4;
  localparam int CODE_W  = 8;

  // mode register bit positions
  localparam int FRZ_ALL   = 0;
  localparam int FRZ_LOW   = 1;
  localparam int FRZ_HIGH  = 2;
  localparam int OVE_FIRST = 3;
  localparam int OVE_REST  = 4;

  localparam logic [CODE_W-1:0] EV_INSN     = 8'h02;
  localparam logic [CODE_W-1:0] EV_CYC      = 8'h1E;
  localparam logic [CODE_W-1:0] EV_INSN_ALT = 8'hFE;
  localparam logic [CODE_W-1:0] EV_CYC_ALT  = 8'hF0;
  localparam logic [CODE_W-1:0] EV_RUN_INSN = 8'hFA;

  typedef struct packed {
    logic [NUM_CNT-1:0] cntEn;
    logic [NUM_CNT-1:0] insnSel;
    logic [NUM_CNT-1:0] clampEn;
    logic [NUM_CNT-1:0] wrCnt;
  } evtc_strobe_t;

  // returns {countsInsn, countsCycles} for a selectable counter
  function automatic logic [1:0] decodeCode(input int idx, input logic [CODE_W-1:0] code);
    logic insn;
    logic cyc;
    insn = (code == EV_INSN)
         || (idx == 0 && code == EV_INSN_ALT)
         || (idx == 3 && code == EV_RUN_INSN);
    cyc  = (code == EV_CYC) || (idx == 0 && code == EV_CYC_ALT);
    return {insn, cyc};
  endfunction
endpackage

// File: rtl/evtc_ctrl.sv
module evtc_ctrl
  import evtc_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         regSel,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  input  logic               runLatch,
  output evtc_strobe_t       strobe,
  output logic [REG_W-1:0]   ctrl0Q,
  output logic [REG_W-1:0]   ctrl1Q
);
  localparam logic [2:0] SEL_MODE = 3'd6;
  localparam logic [2:0] SEL_EVT  = 3'd7;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrl0Q <= '0;
      ctrl1Q <= '0;
    end else if (wrEn) begin
      if (regSel == SEL_MODE) ctrl0Q <= wrData;
      if (regSel == SEL_EVT)  ctrl1Q <= wrData;
    end
  end

  logic lowGate;
  logic highGate;
  assign lowGate  = !ctrl0Q[FRZ_ALL] && !ctrl0Q[FRZ_LOW] && (ctrl1Q != '0);
  assign highGate = !ctrl0Q[FRZ_ALL] && !ctrl0Q[FRZ_HIGH];

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    logic [CODE_W-1:0] code;
    logic [1:0]        kind;
    logic              runOk;
    assign code  = ctrl1Q[(NUM_SEL-1-i)*CODE_W +: CODE_W];
    assign kind  = decodeCode(i, code);
    assign runOk = (i != 3) || (code != EV_RUN_INSN) || runLatch;
    assign strobe.cntEn[i]   = lowGate && (|kind) && runOk;
    assign strobe.insnSel[i] = kind[1];
  end

  assign strobe.cntEn[4]   = highGate;
  assign strobe.insnSel[4] = 1'b1;
  assign strobe.cntEn[5]   = highGate;
  assign strobe.insnSel[5] = 1'b0;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_str
    assign strobe.clampEn[i] = (i == 0) ? ctrl0Q[OVE_FIRST] : ctrl0Q[OVE_REST];
    assign strobe.wrCnt[i]   = wrEn && (regSel == 3'(i));
  end
endmodule

// File: rtl/evtc_datapath.sv
module evtc_datapath
  import evtc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int INSN_W = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  evtc_strobe_t              strobe,
  input  logic [CNT_W-1:0]          wrData,
  input  logic [INSN_W-1:0]         insnCount,
  output logic [NUM_CNT*CNT_W-1:0]  cntFlat,
  output logic [NUM_CNT-1:0]        ovfPulse
);
  localparam logic [CNT_W:0]   THRESH_W = {2'b01, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] THRESH   = {1'b1, {(CNT_W-1){1'b0}}};

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_lane
    logic [CNT_W-1:0] cntQ;
    logic [CNT_W-1:0] step;
    logic [CNT_W:0]   sumW;
    logic             adv;
    logic             hit;
    logic             pulseQ;

    assign step = strobe.insnSel[i] ? CNT_W'(insnCount) : CNT_W'(1);
    assign adv  = strobe.cntEn[i] && (step != '0);
    assign sumW = {1'b0, cntQ} + {1'b0, step};
    assign hit  = strobe.clampEn[i] && (sumW >= THRESH_W);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ   <= '0;
        pulseQ <= 1'b0;
      end else if (strobe.wrCnt[i]) begin
        cntQ   <= wrData;
        pulseQ <= 1'b0;
      end else if (adv) begin
        cntQ   <= hit ? THRESH : sumW[CNT_W-1:0];
        pulseQ <= hit;
      end else begin
        pulseQ <= 1'b0;
      end
    end

    assign cntFlat[i*CNT_W +: CNT_W] = cntQ;
    assign ovfPulse[i] = pulseQ;
  end
endmodule

// File: rtl/evt_counter_bank.sv
module evt_counter_bank
  import evtc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int INSN_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         regSel,
  input  logic               wrEn,
  input  logic [CNT_W-1:0]   wrData,
  output logic [CNT_W-1:0]   rdData,
  input  logic [INSN_W-1:0]  insnCount,
  input  logic               runLatch,
  output logic [NUM_CNT-1:0] ovfPulse
);
  evtc_strobe_t              strobe;
  logic [CNT_W-1:0]          ctrl0Q;
  logic [CNT_W-1:0]          ctrl1Q;
  logic [NUM_CNT*CNT_W-1:0]  cntFlat;

  evtc_ctrl #(.REG_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .runLatch(runLatch), .strobe(strobe), .ctrl0Q(ctrl0Q), .ctrl1Q(ctrl1Q)
  );

  evtc_datapath #(.CNT_W(CNT_W), .INSN_W(INSN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .insnCount(insnCount), .cntFlat(cntFlat), .ovfPulse(ovfPulse)
  );

  always_comb begin
    case (regSel)
      3'd6:    rdData = ctrl0Q;
      3'd7:    rdData = ctrl1Q;
      default: rdData = cntFlat[regSel*CNT_W +: CNT_W];
    endcase
  end
endmodule

// File: rtl/evtc_checker.sv
module evtc_checker
  import evtc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [2:0]               regSel,
  input logic                     wrEn,
  input logic [CNT_W-1:0]         wrData,
  input logic [NUM_CNT-1:0]       ovfPulse,
  input logic [NUM_CNT*CNT_W-1:0] cntFlat,
  input logic [CNT_W-1:0]         ctrl0Q
);
  localparam logic [CNT_W-1:0] THRESH = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] cycCnt;
  assign cycCnt = cntFlat[5*CNT_W +: CNT_W];

  AST_FREEZE_ALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ctrl0Q[FRZ_ALL] && !wrEn |=> $stable(cntFlat)); // R2

  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl0Q[FRZ_ALL] && !ctrl0Q[FRZ_HIGH] && !(wrEn && regSel == 3'd5)
    |=> (cycCnt == $past(cycCnt) + 1'b1) || (cycCnt == THRESH)); // R4

  AST_FIRST_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse[0] |-> $past(ctrl0Q[OVE_FIRST])); // R9

  AST_SHARED_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (|ovfPulse[NUM_CNT-1:1]) |-> $past(ctrl0Q[OVE_REST])); // R9

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    logic [CNT_W-1:0] cnt;
    assign cnt = cntFlat[i*CNT_W +: CNT_W];

    AST_CLAMP_VALUE: assert property (@(posedge clk) disable iff (!rstN)
      ovfPulse[i] |-> cnt == THRESH); // R8

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
      wrEn && regSel == 3'(i) |=> cnt == $past(wrData) && !ovfPulse[i]); // R11
  end
endmodule

bind evt_counter_bank evtc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
  .ovfPulse(ovfPulse), .cntFlat(cntFlat), .ctrl0Q(ctrl0Q)
);

// File: tb/sim_evt_counter_bank.sv
`timescale 1ns/1ps
module sim_evt_counter_bank;
  localparam int CNT_W  = 32;
  localparam int INSN_W = 3;
  localparam logic [31:0] FZ = 32'h1, OE1 = 32'h8, OER = 32'h10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [2:0]        regSel = '0;
  logic              wrEn = 1'b0;
  logic [CNT_W-1:0]  wrData = '0;
  logic [CNT_W-1:0]  rdData;
  logic [INSN_W-1:0] insnCount = '0;
  logic              runLatch = 1'b0;
  logic [5:0]        ovfPulse;

  always #10 clk = ~clk;

  evt_counter_bank #(.CNT_W(CNT_W), .INSN_W(INSN_W)) u0 (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .insnCount(insnCount), .runLatch(runLatch), .ovfPulse(ovfPulse)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sbQ[$];
  int  nChecks = 0;
  int  nFails  = 0;
  int  ovfSeen[6];
  logic probe = 1'b0;
  logic done  = 1'b0;

  // monitor: compares readback against the scoreboard
  always @(negedge clk) begin
    if (probe && sbQ.size() > 0) begin
      sb_item_t it;
      it = sbQ.pop_front();
      nChecks++;
      if (rdData !== it.exp) begin
        nFails++;
        $display("FAIL %s: actual %h expected %h", it.tag, rdData, it.exp);
      end
    end
    if (rstN) for (int i = 0; i < 6; i++) ovfSeen[i] += int'(ovfPulse[i]);
  end

  task automatic regWrite(input logic [2:0] s, input logic [31:0] d);
    regSel = s; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic runFor(input int k, input logic [INSN_W-1:0] n);
    insnCount = n;
    repeat (k) @(posedge clk);
    #1;
    insnCount = '0;
  endtask

  task automatic expectReg(input logic [2:0] s, input logic [31:0] e, input string tag);
    sb_item_t it;
    it.exp = e; it.tag = tag;
    regSel = s;
    sbQ.push_back(it);
    probe = 1'b1;
    @(posedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic expectNum(input int act, input int e, input string tag);
    nChecks++;
    if (act != e) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, e);
    end
  endtask

  task automatic clearOvf();
    for (int i = 0; i < 6; i++) ovfSeen[i] = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    clearOvf();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values, read while reset is held
    for (int i = 0; i < 8; i++) expectReg(3'(i), 32'h0, "R1 reset");
    rstN = 1'b1;
    regWrite(3'd6, FZ);
    regWrite(3'd4, 32'h0);
    regWrite(3'd5, 32'h0);

    // R5 R6 R7 R4 R10: instruction and cycle counting, run latch low
    regWrite(3'd7, 32'h021E02FA);
    regWrite(3'd6, 32'h0);
    runFor(4, 3'd3);
    regWrite(3'd6, FZ);
    expectReg(3'd0, 32'd12, "R5 insn code 0x02");
    expectReg(3'd1, 32'd5,  "R6 cycle code 0x1E");
    expectReg(3'd2, 32'd12, "R6 insn code 0x02");
    expectReg(3'd3, 32'd0,  "R7 run latch low");
    expectReg(3'd4, 32'd12, "R4 fixed insn counter");
    expectReg(3'd5, 32'd5,  "R10 cycle per clock");

    // R5 R6 R7: alternate codes, idle code, run latch high
    regWrite(3'd7, 32'hF0551EFA);
    runLatch = 1'b1;
    regWrite(3'd6, 32'h0);
    runFor(3, 3'd2);
    regWrite(3'd6, FZ);
    runLatch = 1'b0;
    expectReg(3'd0, 32'd16, "R5 cycle code 0xF0");
    expectReg(3'd1, 32'd5,  "R6 idle code 0x55");
    expectReg(3'd2, 32'd16, "R6 cycle code 0x1E");
    expectReg(3'd3, 32'd6,  "R7 run-gated insn");
    expectReg(3'd4, 32'd18, "R10 multi-add");
    expectReg(3'd5, 32'd9,  "R4 cycles");
    expectReg(3'd7, 32'hF0551EFA, "R1 selection readback");

    // R3: low group frozen
    regWrite(3'd6, 32'h2);
    runFor(2, 3'd1);
    regWrite(3'd6, FZ);
    expectReg(3'd0, 32'd16, "R3 low freeze c1");
    expectReg(3'd3, 32'd6,  "R3 low freeze c4");
    expectReg(3'd4, 32'd20, "R3 high group runs");
    expectReg(3'd5, 32'd12, "R3 high group cycles");

    // R4: high group frozen, R5 code 0xFE
    regWrite(3'd7, 32'hFE020202);
    regWrite(3'd6, 32'h4);
    runFor(2, 3'd1);
    regWrite(3'd6, FZ);
    expectReg(3'd0, 32'd18, "R5 insn code 0xFE");
    expectReg(3'd1, 32'd7,  "R6 c2 insn");
    expectReg(3'd3, 32'd8,  "R7 c4 code 0x02");
    expectReg(3'd4, 32'd20, "R4 c5 frozen");
    expectReg(3'd5, 32'd12, "R4 c6 frozen");

    // R3: all-zero selection keeps 1..4 idle
    regWrite(3'd7, 32'h0);
    regWrite(3'd6, 32'h0);
    runFor(2, 3'd1);
    regWrite(3'd6, FZ);
    expectReg(3'd0, 32'd18, "R3 zero selection c1");
    expectReg(3'd3, 32'd8,  "R3 zero selection c4");
    expectReg(3'd4, 32'd22, "R4 c5 insn");
    expectReg(3'd5, 32'd15, "R4 c6 cycles");

    // R8 R9: counter 1 enable only
    regWrite(3'd0, 32'h7FFFFFFD);
    regWrite(3'd1, 32'h7FFFFFFD);
    regWrite(3'd4, 32'h7FFFFFFE);
    regWrite(3'd5, 32'h7FFFFFFE);
    regWrite(3'd7, 32'h02020000);
    clearOvf();
    regWrite(3'd6, OE1);
    runFor(3, 3'd2);
    regWrite(3'd6, FZ | OE1);
    expectReg(3'd0, 32'h80000000, "R8 clamp c1");
    expectReg(3'd1, 32'h80000003, "R9 c2 unclamped");
    expectReg(3'd4, 32'h80000004, "R9 c5 unclamped");
    expectReg(3'd5, 32'h80000002, "R8 c6 unclamped");
    expectNum(ovfSeen[0], 2, "R8 c1 pulses");
    expectNum(ovfSeen[1], 0, "R9 c2 no pulse");
    expectNum(ovfSeen[5], 0, "R9 c6 no pulse");

    // R8 R9: shared enable
    regWrite(3'd1, 32'h7FFFFFFF);
    regWrite(3'd4, 32'h10);
    regWrite(3'd5, 32'h7FFFFFFD);
    regWrite(3'd7, 32'h00020000);
    clearOvf();
    regWrite(3'd6, OER);
    runFor(2, 3'd1);
    regWrite(3'd6, FZ | OER);
    expectReg(3'd1, 32'h80000000, "R8 clamp c2");
    expectReg(3'd4, 32'h12,       "R9 c5 below threshold");
    expectReg(3'd5, 32'h80000000, "R8 clamp c6");
    expectNum(ovfSeen[1], 2, "R8 c2 pulses");
    expectNum(ovfSeen[4], 0, "R8 c5 no pulse");
    expectNum(ovfSeen[5], 1, "R9 c6 pulse");
    expectNum(ovfSeen[0], 0, "R9 c1 idle no pulse");

    // R11: write beats a same-cycle increment
    regWrite(3'd7, 32'h02000000);
    regWrite(3'd0, 32'h0);
    regWrite(3'd4, 32'h100);
    regWrite(3'd6, 32'h0);
    regSel = 3'd4; wrData = 32'h1234; wrEn = 1'b1; insnCount = 3'd4;
    @(posedge clk); #1;
    wrEn = 1'b0; insnCount = '0;
    regWrite(3'd6, FZ);
    expectReg(3'd4, 32'h1234, "R11 write wins");
    expectReg(3'd0, 32'd4,    "R10 same-cycle c1 add");
    expectReg(3'd6, FZ,       "R1 mode readback");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule